// File: doc/BRIEF.md
# Asynchronous Serial Port with Prioritised Receive Status

This block is a byte-oriented asynchronous serial port for a host that reaches it through a small four-address register window. A byte written to the transmit holding register is moved into a transmit shifter as soon as the line is free, and goes out as start bit, eight data bits (least significant first), an optional even or odd parity bit, and one stop bit. The receiver oversamples the line sixteen times per bit, takes each bit at its middle, and places the result into a receive holding register.

The main concern is what the status flags and the holding register do when one frame carries more than one error. An overrun leaves the earlier byte and its full flag untouched. Parity or framing trouble without an overrun still delivers the byte but does not mark it full. Any pending error blocks further deliveries until the host clears the flags. Three interrupt request lines are gated by two enables. A priority code names the most urgent request.

Top module: `uart_core`

## Requirements
- R1: After reset the status register reads 0x80 (only the transmit-empty flag set), the control register reads 0x00, the serial output is 1 and all three interrupt lines and the priority code are 0.
- R2: Register window (bus_rdata shows the addressed register at all times): address 0 is control with bit0 parity enable, bit1 odd parity, bit6 receive interrupt enable, bit7 transmit interrupt enable; address 1 is transmit holding; address 2 is status with bit7 transmit-empty, bit6 receive-full, bit5 overrun, bit4 framing error, bit3 parity error, other bits 0; address 3 is receive holding.
- R3: A transmitted frame is a 0 start bit, eight data bits LSB first, then when enabled a parity bit equal to the XOR of the data bits (inverted for odd parity), then a 1 stop bit; each bit lasts 16*DIV clocks.
- R4: Transmit-empty goes to 1 when the holding byte is copied into the shifter and goes to 0 on a write to address 1. A write while it is 0 replaces the uncopied byte, which is never sent.
- R5: The receiver samples each bit at its midpoint. A falling edge whose line is back at 1 at the start-bit midpoint is ignored and changes no state.
- R6: A frame with no error, arriving while receive-full and all error flags are 0, is written to the receive holding register and sets receive-full.
- R7: A frame with a parity error, a framing error (stop bit sampled 0) or both, arriving while receive-full and all error flags are 0, is written to the receive holding register, sets the matching error flags and leaves receive-full at 0.
- R8: A frame completing while receive-full is 1 and no error flag is set leaves the receive holding register and receive-full unchanged and sets overrun, together with framing and parity error when those also apply.
- R9: While any of overrun, framing or parity error is 1, a completed frame changes neither the receive holding register nor any flag.
- R10: Writing 0 to a receive flag bit in the status register clears it only when an earlier read strobe of the status register saw it at 1. Writing 1 has no effect, and status writes never change transmit-empty.
- R11: The receive-error line is 1 when any error flag and the receive interrupt enable are 1. The receive-end line is receive-full AND that enable. The transmit-end line is transmit-empty AND the transmit interrupt enable.
- R12: The priority code is 1 when the receive-error line is active, else 2 when receive-end is active, else 3 when transmit-end is active, else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe; at address 2 it arms flag clearing |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Contents of the addressed register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx_err | output | 1 | Receive-error request |
| irq_rx_end | output | 1 | Receive-end request |
| irq_tx_end | output | 1 | Transmit-end request |
| irq_top | output | 2 | Code of the highest-priority active request |

## Verification
The assertions assume that the control register is not rewritten while a frame is moving in either direction. They also assume that rxd changes no faster than one bit time, so every completed frame reaches the status logic as a single one-cycle result. The bench writes the control register only between frames. It drives rxd at exactly sixteen clocks per bit, and asserts read and write strobes only on idle bus cycles away from frame completion. The only sub-bit pulse it applies is the deliberately short start glitch.

// File: rtl/uart_pkg.sv
package uart_pkg;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_START,
        SER_DATA,
        SER_PAR,
        SER_STOP
    } ser_state_e;

    typedef struct packed {
        logic tie;
        logic rie;
        logic par_odd;
        logic par_en;
    } uart_cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_frame_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TXD  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_RXD  = 2'd3;

    // receive flag vector indices (status bits 6..3)
    localparam int F_RF = 3;
    localparam int F_OV = 2;
    localparam int F_FE = 1;
    localparam int F_PE = 0;

    localparam int OVS      = 16;
    localparam int OVS_W    = $clog2(OVS);
    localparam int HALF_BIT = OVS / 2;

    localparam logic [1:0] IRQ_NONE = 2'd0;
    localparam logic [1:0] IRQ_RERR = 2'd1;
    localparam logic [1:0] IRQ_REND = 2'd2;
    localparam logic [1:0] IRQ_TEND = 2'd3;

    function automatic logic par_bit(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/uart_tick.sv
module uart_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       pend,
    input  logic [7:0] data,
    output logic       take,
    output logic       txd
);
    ser_state_e       state;
    logic [OVS_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             par;

    assign take = (state == SER_IDLE) && pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SER_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
            par   <= 1'b0;
        end else if (state == SER_IDLE) begin
            if (take) begin
                sh    <= data;
                par   <= par_bit(data, par_odd);
                cnt   <= '0;
                state <= SER_START;
            end
        end else if (tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == OVS_W'(OVS - 1)) begin
                unique case (state)
                    SER_START: begin
                        bitn  <= '0;
                        state <= SER_DATA;
                    end
                    SER_DATA: begin
                        sh   <= {1'b0, sh[7:1]};
                        bitn <= bitn + 1'b1;
                        if (bitn == 3'd7) state <= par_en ? SER_PAR : SER_STOP;
                    end
                    SER_PAR:  state <= SER_STOP;
                    SER_STOP: state <= SER_IDLE;
                    default:  state <= SER_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            SER_START: txd = 1'b0;
            SER_DATA:  txd = sh[0];
            SER_PAR:   txd = par;
            default:   txd = 1'b1;
        endcase
    end

    // a copied byte is followed by the start bit on the next cycle
    p_start_follows_take_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> (txd == 1'b0));

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      done,
    output rx_frame_t frame
);
    ser_state_e       state;
    logic [OVS_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             perr;
    logic             s1, s2, s_prev;
    logic             fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            s_prev <= 1'b1;
        end else begin
            s1     <= rxd;
            s2     <= s1;
            s_prev <= s2;
        end
    end

    assign fall = s_prev && !s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SER_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
            perr  <= 1'b0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            if (state == SER_IDLE) begin
                if (fall) begin
                    cnt   <= '0;
                    state <= SER_START;
                end
            end else if (tick) begin
                cnt <= cnt + 1'b1;
                unique case (state)
                    SER_START: begin
                        if (cnt == OVS_W'(HALF_BIT - 1)) begin
                            cnt <= '0;
                            if (!s2) begin
                                bitn  <= '0;
                                perr  <= 1'b0;
                                state <= SER_DATA;
                            end else begin
                                state <= SER_IDLE;
                            end
                        end
                    end
                    SER_DATA: begin
                        if (cnt == OVS_W'(OVS - 1)) begin
                            sh   <= {s2, sh[7:1]};
                            bitn <= bitn + 1'b1;
                            if (bitn == 3'd7) state <= par_en ? SER_PAR : SER_STOP;
                        end
                    end
                    SER_PAR: begin
                        if (cnt == OVS_W'(OVS - 1)) begin
                            perr  <= (s2 != par_bit(sh, par_odd));
                            state <= SER_STOP;
                        end
                    end
                    SER_STOP: begin
                        if (cnt == OVS_W'(OVS - 1)) begin
                            done       <= 1'b1;
                            frame.data <= sh;
                            frame.perr <= perr;
                            frame.ferr <= !s2;
                            state      <= SER_IDLE;
                        end
                    end
                    default: state <= SER_IDLE;
                endcase
            end
        end
    end

    // each frame yields exactly one result pulse
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // a result is only produced on leaving the stop bit
    p_done_from_stop_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == SER_IDLE));

endmodule

// File: rtl/uart_regs.sv
module uart_regs
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_done,
    input  rx_frame_t  rx_frame,
    input  logic       tx_take,
    output logic       tx_pend,
    output logic [7:0] tx_data,
    output logic       par_en,
    output logic       par_odd,
    output logic       irq_rx_err,
    output logic       irq_rx_end,
    output logic       irq_tx_end,
    output logic [1:0] irq_top
);
    uart_cfg_t  cfg;
    logic [7:0] tdr;
    logic [7:0] rdr;
    logic       te;
    logic [3:0] flg;
    logic [3:0] arm;
    logic [3:0] clr;
    logic [3:0] flg_n;
    logic       load;
    logic       any_err;
    logic       wr_ctrl, wr_tdr, wr_stat, rd_stat;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_tdr  = bus_wr && (bus_addr == ADDR_TXD);
    assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
    assign rd_stat = bus_rd && (bus_addr == ADDR_STAT);
    assign any_err = flg[F_OV] | flg[F_FE] | flg[F_PE];

    always_comb begin
        clr   = wr_stat ? (arm & ~bus_wdata[6:3]) : 4'b0000;
        flg_n = flg & ~clr;
        load  = 1'b0;
        if (rx_done && !any_err) begin
            if (flg[F_RF]) begin
                flg_n[F_OV] = 1'b1;
                flg_n[F_FE] = flg_n[F_FE] | rx_frame.ferr;
                flg_n[F_PE] = flg_n[F_PE] | rx_frame.perr;
            end else begin
                load = 1'b1;
                if (rx_frame.ferr || rx_frame.perr) begin
                    flg_n[F_FE] = flg_n[F_FE] | rx_frame.ferr;
                    flg_n[F_PE] = flg_n[F_PE] | rx_frame.perr;
                end else begin
                    flg_n[F_RF] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            tdr <= '0;
            rdr <= '0;
            te  <= 1'b1;
            flg <= '0;
            arm <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.tie     <= bus_wdata[7];
                cfg.rie     <= bus_wdata[6];
                cfg.par_odd <= bus_wdata[1];
                cfg.par_en  <= bus_wdata[0];
            end
            if (wr_tdr) begin
                tdr <= bus_wdata;
                te  <= 1'b0;
            end else if (tx_take) begin
                te  <= 1'b1;
            end
            if (rd_stat) arm <= flg;
            else         arm <= arm & ~clr;
            flg <= flg_n;
            if (load) rdr <= rx_frame.data;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = {cfg.tie, cfg.rie, 4'b0000, cfg.par_odd, cfg.par_en};
            ADDR_TXD:  bus_rdata = tdr;
            ADDR_STAT: bus_rdata = {te, flg, 3'b000};
            default:   bus_rdata = rdr;
        endcase
    end

    assign tx_pend = !te;
    assign tx_data = tdr;
    assign par_en  = cfg.par_en;
    assign par_odd = cfg.par_odd;

    assign irq_rx_err = any_err && cfg.rie;
    assign irq_rx_end = flg[F_RF] && cfg.rie;
    assign irq_tx_end = te && cfg.tie;

    always_comb begin
        if (irq_rx_err)      irq_top = IRQ_RERR;
        else if (irq_rx_end) irq_top = IRQ_REND;
        else if (irq_tx_end) irq_top = IRQ_TEND;
        else                 irq_top = IRQ_NONE;
    end

    // copying the holding byte into the shifter raises transmit-empty
    p_take_sets_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_take && !wr_tdr) |=> te);

    // an overrun never disturbs the held byte
    p_overrun_keeps_data_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(flg[F_OV]) |-> $stable(rdr));

    // an erroneous frame is delivered but not marked full
    p_error_frame_not_full_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !flg[F_RF] && !any_err && (rx_frame.ferr || rx_frame.perr))
        |=> (!flg[F_RF] && rdr == $past(rx_frame.data)));

    // pending errors block delivery
    p_blocked_while_error_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_done && any_err) |=> $stable(rdr));

    // the error request always wins the priority code
    p_error_on_top_r12: assert property (@(posedge clk) disable iff (rst)
        irq_rx_err |-> (irq_top == IRQ_RERR));

endmodule

// File: rtl/uart_core.sv
module uart_core
    import uart_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq_rx_err,
    output logic       irq_rx_end,
    output logic       irq_tx_end,
    output logic [1:0] irq_top
);
    logic       tick;
    logic       rx_done;
    rx_frame_t  rx_frame;
    logic       tx_take;
    logic       tx_pend;
    logic [7:0] tx_data;
    logic       par_en;
    logic       par_odd;

    uart_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    uart_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .par_en  (par_en),
        .par_odd (par_odd),
        .pend    (tx_pend),
        .data    (tx_data),
        .take    (tx_take),
        .txd     (txd)
    );

    uart_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .rxd     (rxd),
        .par_en  (par_en),
        .par_odd (par_odd),
        .done    (rx_done),
        .frame   (rx_frame)
    );

    uart_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .rx_done    (rx_done),
        .rx_frame   (rx_frame),
        .tx_take    (tx_take),
        .tx_pend    (tx_pend),
        .tx_data    (tx_data),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .irq_rx_err (irq_rx_err),
        .irq_rx_end (irq_rx_end),
        .irq_tx_end (irq_tx_end),
        .irq_top    (irq_top)
    );

endmodule

// File: tb/uart_core_tb.sv
module uart_core_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd;
    logic       irq_rx_err, irq_rx_end, irq_tx_end;
    logic [1:0] irq_top;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    uart_core #(.DIV(1)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
        .irq_rx_err(irq_rx_err), .irq_rx_end(irq_rx_end), .irq_tx_end(irq_tx_end),
        .irq_top(irq_top)
    );

    // {clear_first, bad_par, bad_stop, data, exp_status, exp_rxdata}, even parity
    localparam int NV = 13;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 8'hA5, 8'hC0, 8'hA5},  // R6 clean frame
        {1'b1, 1'b1, 1'b0, 8'h3C, 8'h88, 8'h3C},  // R7 parity only
        {1'b1, 1'b0, 1'b1, 8'h0F, 8'h90, 8'h0F},  // R7 framing only
        {1'b1, 1'b1, 1'b1, 8'h81, 8'h98, 8'h81},  // R7 framing + parity
        {1'b1, 1'b0, 1'b0, 8'h55, 8'hC0, 8'h55},  // R6
        {1'b0, 1'b0, 1'b0, 8'h66, 8'hE0, 8'h55},  // R8 overrun alone
        {1'b1, 1'b0, 1'b0, 8'h11, 8'hC0, 8'h11},  // R6
        {1'b0, 1'b1, 1'b0, 8'h22, 8'hE8, 8'h11},  // R8 overrun + parity
        {1'b1, 1'b0, 1'b0, 8'h44, 8'hC0, 8'h44},  // R6
        {1'b0, 1'b1, 1'b1, 8'h99, 8'hF8, 8'h44},  // R8 overrun + framing + parity
        {1'b0, 1'b0, 1'b0, 8'h77, 8'hF8, 8'h44},  // R9 blocked
        {1'b1, 1'b0, 1'b1, 8'h12, 8'h90, 8'h12},  // R7
        {1'b0, 1'b0, 1'b0, 8'h34, 8'h90, 8'h12}   // R9 blocked
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_strobe_status();
        @(negedge clk);
        bus_addr = 2'd2; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clear_all();
        read_strobe_status();
        bus_write(2'd2, 8'h00);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pe, input logic odd,
                              input logic bad_par, input logic bad_stop);
        @(negedge clk);
        rxd = 1'b0;
        clocks(16);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            clocks(16);
        end
        if (pe) begin
            rxd = (^d) ^ odd ^ bad_par;
            clocks(16);
        end
        rxd = !bad_stop;
        clocks(16);
        rxd = 1'b1;
        clocks(6);
    endtask

    task automatic capture_tx(input logic pe, output logic [7:0] d, output logic p,
                              output logic st, output logic sp);
        int guard = 0;
        d = 8'h00; p = 1'b0;
        while (txd !== 1'b0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        clocks(8);
        st = txd;
        for (int i = 0; i < 8; i++) begin
            clocks(16);
            d[i] = txd;
        end
        if (pe) begin
            clocks(16);
            p = txd;
        end
        clocks(16);
        sp = txd;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] d1, d2;
        logic       p, st, sp;

        clocks(3);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        peek(2'd2, v); chk("R1 status", v, 8'h80);
        peek(2'd0, v); chk("R1 control", v, 8'h00);
        chk("R1 txd", {7'd0, txd}, 8'h01);
        chk("R1 irqs", {5'd0, irq_rx_err, irq_rx_end, irq_tx_end}, 8'h00);
        chk("R1 irq_top", {6'd0, irq_top}, 8'h00);

        // R2 control readback
        bus_write(2'd0, 8'hC3);
        peek(2'd0, v); chk("R2 control readback", v, 8'hC3);
        bus_write(2'd0, 8'h01);

        // R3 transmit frame with even parity
        bus_write(2'd1, 8'hB4);
        capture_tx(1'b1, d1, p, st, sp);
        chk("R3 start bit", {7'd0, st}, 8'h00);
        chk("R3 data", d1, 8'hB4);
        chk("R3 parity", {7'd0, p}, {7'd0, ^8'hB4});
        chk("R3 stop bit", {7'd0, sp}, 8'h01);
        clocks(20);
        peek(2'd2, v); chk("R4 empty after copy", v[7:0] & 8'h80, 8'h80);

        // R4 overwrite of an uncopied byte loses it
        bus_write(2'd1, 8'h5A);
        fork
            capture_tx(1'b1, d1, p, st, sp);
            begin
                clocks(3);
                bus_write(2'd1, 8'h11);
                bus_write(2'd1, 8'h7E);
            end
        join
        peek(2'd2, v); chk("R4 empty low while byte waits", v & 8'h80, 8'h00);
        chk("R4 first frame", d1, 8'h5A);
        capture_tx(1'b1, d2, p, st, sp);
        chk("R4 second frame is replacement", d2, 8'h7E);
        clocks(20);

        // R6 R7 R8 R9 vector table, even parity
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][26]) clear_all();
            send_frame(VEC[i][23:16], 1'b1, 1'b0, VEC[i][25], VEC[i][24]);
            peek(2'd2, v); chk($sformatf("R6-table status %0d", i), v, VEC[i][15:8]);
            peek(2'd3, v); chk($sformatf("R8 table data %0d", i), v, VEC[i][7:0]);
        end

        // R10 clear needs an earlier read strobe; writing 1 does nothing
        clear_all();
        send_frame(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0);
        bus_write(2'd2, 8'h00);
        peek(2'd2, v); chk("R10 clear without read ignored", v, 8'hC0);
        read_strobe_status();
        bus_write(2'd2, 8'hFF);
        peek(2'd2, v); chk("R10 writing ones ignored", v, 8'hC0);
        bus_write(2'd2, 8'h00);
        peek(2'd2, v); chk("R10 clear after read, empty kept", v, 8'h80);

        // R5 start glitch rejected
        @(negedge clk) rxd = 1'b0;
        clocks(4);
        rxd = 1'b1;
        clocks(300);
        peek(2'd2, v); chk("R5 glitch no frame", v, 8'h80);
        peek(2'd3, v); chk("R5 glitch data unchanged", v, 8'hC3);

        // R3 R6 odd parity and no parity receive
        bus_write(2'd0, 8'h03);
        send_frame(8'h6B, 1'b1, 1'b1, 1'b0, 1'b0);
        peek(2'd2, v); chk("R6 odd parity status", v, 8'hC0);
        peek(2'd3, v); chk("R6 odd parity data", v, 8'h6B);
        clear_all();
        bus_write(2'd0, 8'h00);
        send_frame(8'h2D, 1'b0, 1'b0, 1'b0, 1'b0);
        peek(2'd2, v); chk("R6 no parity status", v, 8'hC0);
        peek(2'd3, v); chk("R6 no parity data", v, 8'h2D);
        clear_all();

        // R11 R12 interrupts
        bus_write(2'd0, 8'h80);
        peek(2'd2, v);
        chk("R11 tx end", {5'd0, irq_rx_err, irq_rx_end, irq_tx_end}, 8'h01);
        chk("R12 code tx end", {6'd0, irq_top}, 8'h03);
        bus_write(2'd0, 8'hC1);
        send_frame(8'h10, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R11 rx end", {5'd0, irq_rx_err, irq_rx_end, irq_tx_end}, 8'h03);
        chk("R12 code rx end", {6'd0, irq_top}, 8'h02);
        send_frame(8'h20, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R11 rx error", {5'd0, irq_rx_err, irq_rx_end, irq_tx_end}, 8'h07);
        chk("R12 code rx error", {6'd0, irq_top}, 8'h01);
        clear_all();
        bus_write(2'd0, 8'h41);
        peek(2'd2, v);
        chk("R11 gated off", {5'd0, irq_rx_err, irq_rx_end, irq_tx_end}, 8'h00);
        chk("R12 code none", {6'd0, irq_top}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule